// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers per-channel interrupt events from a multi-channel DMA engine and presents them to a host through a small register port. Each physical channel can raise three kinds of event: transfer done, fault class A and fault class B. Each kind keeps its own sticky raw latch bank, its own enable mask and a masked status view. A combined word flags every channel with any enabled event pending, and a single registered interrupt line follows that word.

The host enables channels through the mask registers. It reads the combined word and services channels from the lowest set bit upward, using the per-kind status words to tell the event kinds apart. It then clears the serviced raw bits by writing ones to them. A dedicated clear-all address drops one channel's bits in all three raw banks with a single write, which is what terminating a channel needs. Register reads are combinational from the address. Writes take effect at the clock edge.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset every raw bit and every mask bit is 0, the interrupt output is 0, and every register address reads 0.
- R2: An event pulse on channel i of a kind sets bit i of that kind's raw register. Bit i becomes readable on the next cycle at the raw address: 7 for done, 8 for fault A, 9 for fault B.
- R3: A write to a mask address (4 done, 5 fault A, 6 fault B) stores the low NCH data bits. A 1 enables that channel's event for that kind. Reads return the stored value, with the bits above NCH reading as 0.
- R4: A write to a raw address clears each raw bit written with 1 and leaves each raw bit written with 0 unchanged.
- R5: The per-kind status addresses (1 done, 2 fault A, 3 fault B) read the raw bits ANDed with that kind's mask.
- R6: Address 0 reads the combined status: bit i is the OR of bit i of the three per-kind status words.
- R7: A write to address 10 clears, for each data bit written as 1, that channel's bit in all three raw registers at once. Address 10 reads 0.
- R8: An event pulse in the same cycle as a clearing write to the same raw bit wins, and the bit stays set.
- R9: The interrupt output is registered. It equals, one cycle later, the OR of all bits of the combined status.
- R10: Writes to addresses 0–3 and 11–15 change no state. Addresses 11–15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| done_evt | input | NCH | Per-channel transfer-done event pulses |
| fault_a_evt | input | NCH | Per-channel fault class A event pulses |
| fault_b_evt | input | NCH | Per-channel fault class B event pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench walks a single-channel event through every channel of every kind, so a swapped kind or a wrong bit index shows up at the raw addresses. Mask patterns with alternating bits, a single bit and all ones are then applied to mixed pending events. These separate the per-kind status words from the combined word, and they show the interrupt rising and falling one cycle behind. Clear writes with mixed one and zero bits, clear-all writes and event-versus-clear collisions show that write-one-to-clear acts only on the chosen bits and that the event wins. Writes to read-only and unused addresses are followed by full register sweeps to show that no state moved.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int KINDS = 3;
  localparam int AW    = 4;

  localparam logic [AW-1:0] A_COMBINED  = 4'd0;
  localparam logic [AW-1:0] A_STAT_BASE = 4'd1;
  localparam logic [AW-1:0] A_MASK_BASE = 4'd4;
  localparam logic [AW-1:0] A_RAW_BASE  = 4'd7;
  localparam logic [AW-1:0] A_CLR_ALL   = 4'd10;

  function automatic logic [AW-1:0] stat_addr(input int k);
    return A_STAT_BASE + AW'(k);
  endfunction
  function automatic logic [AW-1:0] mask_addr(input int k);
    return A_MASK_BASE + AW'(k);
  endfunction
  function automatic logic [AW-1:0] raw_addr(input int k);
    return A_RAW_BASE + AW'(k);
  endfunction
endpackage

// File: rtl/dma_irq_kind_bank.sv
module dma_irq_kind_bank #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ev,
  input  logic           mask_we,
  input  logic           raw_clr_we,
  input  logic [NCH-1:0] wbits,
  output logic [NCH-1:0] raw_q,
  output logic [NCH-1:0] mask_q,
  output logic [NCH-1:0] pend
);
  function automatic logic [NCH-1:0] sticky_next(input logic [NCH-1:0] cur,
                                                 input logic [NCH-1:0] clr,
                                                 input logic [NCH-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [NCH-1:0] gate(input logic [NCH-1:0] r,
                                          input logic [NCH-1:0] m);
    return r & m;
  endfunction

  logic [NCH-1:0] clr_bits;
  logic [NCH-1:0] raw_d;

  assign clr_bits = raw_clr_we ? wbits : '0;
  assign raw_d    = sticky_next(raw_q, clr_bits, ev);
  assign pend     = gate(raw_q, mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= raw_d;
      if (mask_we) mask_q <= wbits;
    end
  end

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((raw_q & $past(ev)) == $past(ev)));

  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    raw_clr_we |=> ((raw_q & $past(wbits & ~ev)) == '0));

  a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & $past(raw_q & ~clr_bits)) == $past(raw_q & ~clr_bits)));

  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_clr_we && |(ev & wbits)) |=> ((raw_q & $past(ev & wbits)) == $past(ev & wbits)));

  a_r3_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(wbits)));

  a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));
endmodule

// File: rtl/dma_irq_regmap.sv
module dma_irq_regmap
  import dma_irq_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DW  = 32
) (
  input  logic                       reg_wr,
  input  logic [AW-1:0]              reg_addr,
  input  logic [KINDS-1:0][NCH-1:0]  raw,
  input  logic [KINDS-1:0][NCH-1:0]  mask,
  input  logic [KINDS-1:0][NCH-1:0]  pend,
  input  logic [NCH-1:0]             combined,
  output logic [KINDS-1:0]           mask_we,
  output logic [KINDS-1:0]           raw_we,
  output logic                       clr_all_we,
  output logic [DW-1:0]              rdata
);
  always_comb begin
    for (int k = 0; k < KINDS; k++) begin
      mask_we[k] = reg_wr && (reg_addr == mask_addr(k));
      raw_we[k]  = reg_wr && (reg_addr == raw_addr(k));
    end
    clr_all_we = reg_wr && (reg_addr == A_CLR_ALL);
  end

  always_comb begin
    rdata = '0;
    if (reg_addr == A_COMBINED) rdata[NCH-1:0] = combined;
    for (int k = 0; k < KINDS; k++) begin
      if (reg_addr == stat_addr(k)) rdata[NCH-1:0] = pend[k];
      if (reg_addr == mask_addr(k)) rdata[NCH-1:0] = mask[k];
      if (reg_addr == raw_addr(k))  rdata[NCH-1:0] = raw[k];
    end
  end

  always_comb begin
    a_r10_one_strobe: assert ($onehot0({mask_we, raw_we, clr_all_we}));
    if (!reg_wr) a_r10_idle_no_strobe: assert ({mask_we, raw_we, clr_all_we} == '0);
  end
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] done_evt,
  input  logic [NCH-1:0] fault_a_evt,
  input  logic [NCH-1:0] fault_b_evt,
  input  logic           reg_wr,
  input  logic [3:0]     reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           irq
);
  logic [KINDS-1:0][NCH-1:0] evts;
  logic [KINDS-1:0][NCH-1:0] raw_v;
  logic [KINDS-1:0][NCH-1:0] mask_v;
  logic [KINDS-1:0][NCH-1:0] pend_v;
  logic [KINDS-1:0]          mask_we;
  logic [KINDS-1:0]          raw_we;
  logic                      clr_all_we;
  logic [NCH-1:0]            combined;
  logic                      any_pending;

  assign evts = {fault_b_evt, fault_a_evt, done_evt};

  function automatic logic [NCH-1:0] merge(input logic [KINDS-1:0][NCH-1:0] p);
    logic [NCH-1:0] acc;
    acc = '0;
    for (int k = 0; k < KINDS; k++) acc |= p[k];
    return acc;
  endfunction

  for (genvar k = 0; k < KINDS; k++) begin : g_kind
    dma_irq_kind_bank #(.NCH(NCH)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev         (evts[k]),
      .mask_we    (mask_we[k]),
      .raw_clr_we (raw_we[k] | clr_all_we),
      .wbits      (reg_wdata[NCH-1:0]),
      .raw_q      (raw_v[k]),
      .mask_q     (mask_v[k]),
      .pend       (pend_v[k])
    );
  end

  assign combined    = merge(pend_v);
  assign any_pending = |combined;

  dma_irq_regmap #(.NCH(NCH), .DW(DW)) u_map (
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .raw        (raw_v),
    .mask       (mask_v),
    .pend       (pend_v),
    .combined   (combined),
    .mask_we    (mask_we),
    .raw_we     (raw_we),
    .clr_all_we (clr_all_we),
    .rdata      (reg_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= any_pending;
  end

  a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    any_pending |=> irq);
  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pending |=> !irq);
  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_we |=> ((raw_v[0] | raw_v[1] | raw_v[2]) & $past(reg_wdata[NCH-1:0] & ~(done_evt | fault_a_evt | fault_b_evt))) == '0);
endmodule

// File: tb/dma_irq_agg_bench.sv
module dma_irq_agg_bench;
  localparam int NCH = 16;
  localparam int DW  = 32;
  localparam time TCLK = 10ns;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] done_evt = '0, fault_a_evt = '0, fault_b_evt = '0;
  logic           reg_wr = 1'b0;
  logic [3:0]     reg_addr = '0;
  logic [DW-1:0]  reg_wdata = '0;
  logic [DW-1:0]  reg_rdata;
  logic           irq;

  dma_irq_agg #(.NCH(NCH), .DW(DW)) u_dma_irq_agg (
    .clk(clk), .rst_n(rst_n), .done_evt(done_evt), .fault_a_evt(fault_a_evt),
    .fault_b_evt(fault_b_evt), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #(TCLK/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [NCH-1:0] m_raw [3];
  logic [NCH-1:0] m_mask[3];
  logic           m_irq;

  function automatic logic [NCH-1:0] m_comb();
    logic [NCH-1:0] c = '0;
    for (int k = 0; k < 3; k++) c = c | (m_raw[k] & m_mask[k]);
    return c;
  endfunction

  function automatic logic [DW-1:0] m_read(input int a);
    logic [DW-1:0] v = '0;
    if (a == 0) v[NCH-1:0] = m_comb();
    else if (a >= 1 && a <= 3) v[NCH-1:0] = m_raw[a-1] & m_mask[a-1];
    else if (a >= 4 && a <= 6) v[NCH-1:0] = m_mask[a-4];
    else if (a >= 7 && a <= 9) v[NCH-1:0] = m_raw[a-7];
    return v;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock with given stimulus; model updated bit by bit
  task automatic step(input logic [NCH-1:0] e0, input logic [NCH-1:0] e1,
                      input logic [NCH-1:0] e2, input logic wr,
                      input int a, input logic [DW-1:0] wd);
    logic [NCH-1:0] ev[3];
    ev[0] = e0; ev[1] = e1; ev[2] = e2;
    done_evt = e0; fault_a_evt = e1; fault_b_evt = e2;
    reg_wr = wr; reg_addr = 4'(a); reg_wdata = wd;
    @(posedge clk);
    m_irq = |m_comb();
    for (int k = 0; k < 3; k++) begin
      for (int b = 0; b < NCH; b++) begin
        if (ev[k][b]) m_raw[k][b] = 1'b1;
        else if (wr && (a == 7 + k || a == 10) && wd[b]) m_raw[k][b] = 1'b0;
      end
      if (wr && a == 4 + k) m_mask[k] = wd[NCH-1:0];
    end
    @(negedge clk);
    done_evt = '0; fault_a_evt = '0; fault_b_evt = '0; reg_wr = 1'b0;
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < 16; a++) begin
      reg_addr = 4'(a);
      #1;
      check(req, reg_rdata, m_read(a));
    end
    check({req, " irq"}, {31'd0, irq}, {31'd0, m_irq});
  endtask

  initial begin
    #(TCLK * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) begin m_raw[k] = '0; m_mask[k] = '0; end
    m_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    // R2: walk one event through every channel of every kind
    for (int k = 0; k < 3; k++)
      for (int c = 0; c < NCH; c++) begin
        logic [NCH-1:0] one = NCH'(1) << c;
        step(k == 0 ? one : '0, k == 1 ? one : '0, k == 2 ? one : '0, 1'b0, 0, '0);
        reg_addr = 4'(7 + k); #1;
        check("R2 raw set", reg_rdata, m_read(7 + k));
        step('0, '0, '0, 1'b1, 7 + k, DW'(one));
        reg_addr = 4'(7 + k); #1;
        check("R4 raw cleared", reg_rdata, '0);
      end

    // R3/R5/R6/R9: pending mix under several masks
    step(16'hF0F0, 16'h0FF0, 16'h8001, 1'b0, 0, '0);
    check_all("R5 masks zero");
    step('0, '0, '0, 1'b1, 4, 32'hFFFF_AAAA);
    check_all("R3 mask done alt");
    step('0, '0, '0, 1'b0, 0, '0);
    check_all("R9 irq lag");
    step('0, '0, '0, 1'b1, 5, 32'h0000_0100);
    step('0, '0, '0, 1'b1, 6, 32'h0000_FFFF);
    check_all("R6 combined");
    step('0, '0, '0, 1'b1, 4, 32'h0);
    check_all("R3 mask cleared");

    // R4: mixed 1/0 clear pattern
    step('0, '0, '0, 1'b1, 8, 32'h0000_00F0);
    check_all("R4 mixed clear");

    // R8: collision event and clear on same bit
    step(16'h0010, '0, '0, 1'b1, 7, 32'h0000_0030);
    check_all("R8 event wins");

    // R7: clear-all drops a channel in every bank
    step(16'h0001, 16'h0001, 16'h0001, 1'b0, 0, '0);
    step('0, '0, '0, 1'b1, 10, 32'h0000_8011);
    check_all("R7 clear all");

    // R10: writes to read-only and unused addresses
    for (int a = 0; a < 16; a++)
      if (a < 4 || a > 10) begin
        step('0, '0, '0, 1'b1, a, 32'hFFFF_FFFF);
        check_all("R10 no effect");
      end

    // drain everything, irq drops
    step('0, '0, '0, 1'b1, 10, 32'hFFFF);
    step('0, '0, '0, 1'b0, 0, '0);
    check_all("R9 irq drop");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule